// File: doc/BRIEF.md
# Serial Three-Wire EEPROM Slave

This block models the slave side of a small serial EEPROM reached over three wires: a select line, a serial clock and a data-in line, plus one data-out line back to the host. Every flop is clocked by the serial clock, so the block does nothing while that clock is stopped and picks up exactly where it left off when the clock resumes. The storage is a register array of 16-bit words, 128 of them by default.

The host raises select and clocks in an instruction. It starts with a 1 bit, then a 2-bit opcode, then an 8-bit address field, and then 16 data bits for the instructions that carry data. A read answers with one 0 bit followed by the addressed word, most significant bit first. It then keeps streaming the following words, wrapping at the top of the array, until select falls. Every instruction that changes the array needs a prior enable instruction. After a change has been made, the output line reports busy (low) for a fixed number of clocks and then ready (high). Dropping select cancels any instruction that is only partly received.

Top module: `serial_eeprom`

## Requirements
- R1: After reset every word of the array reads as all ones, programming is disabled, and `so` is low.
- R2: Bits are sampled on rising `sck` edges while `cs` is high. Zeros that arrive before the first 1 are ignored. The 1 is followed by a 2-bit opcode and then an 8-bit address field, both MSB first. Opcodes: 10 read, 01 write, 11 erase, 00 extended. Address-field bits above ADDR_W are ignored.
- R3: In a read, `so` is low after the edge that takes the last address bit. The following 16 edges each put out one bit of the addressed word, MSB first.
- R4: While `cs` stays high, a read continues with the next higher addresses without a gap, wrapping from the last word to word 0.
- R5: A write stores the 16 data bits that follow the address (MSB first) into the addressed word.
- R6: Erase sets the addressed word to all ones. Extended code 10 (address field bits [7:6]) sets every word to all ones.
- R7: Extended code 01, followed by 16 data bits, writes that value into every word.
- R8: Extended code 11 enables programming and extended code 00 disables it. While disabled, write, erase and both all-word instructions leave the array unchanged, and `so` stays low.
- R9: `so` goes low at the edge where a change is committed to the array. It goes high at the BUSY_CYC-th rising edge after that edge and stays high while `cs` stays high.
- R10: A rising edge with `cs` low discards any partly received instruction and leaves the array unchanged. The next instruction decodes normally.
- R11: While `sck` is held still, `so` and all other state hold their values. Clocking then resumes the operation that was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Serial clock; all state advances on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs | input | 1 | Select; high frames an instruction |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out; read data or busy/ready |

## Verification
The bench builds the block with ADDR_W = 4 (16 words) and BUSY_CYC = 3. With 16 words, every word can be written and read back with a distinct computed value, and a single streamed read crosses the top-of-array wrap within a few hundred clocks. Address fields carry junk in the bits above ADDR_W, so the don't-care decode is exercised on every access. The short busy window makes it possible to check the exact busy-to-ready edge on every programming instruction, whether programming is enabled or not.

// File: rtl/serial_eeprom_pkg.sv
package serial_eeprom_pkg;
    localparam int AFIELD_W = 8;
    localparam int CMD_W    = 2 + AFIELD_W;

    localparam logic [1:0] OP_EXT   = 2'b00;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_ERASE = 2'b11;

    localparam logic [1:0] EXT_LOCK  = 2'b00;
    localparam logic [1:0] EXT_FILL  = 2'b01;
    localparam logic [1:0] EXT_CLEAR = 2'b10;
    localparam logic [1:0] EXT_OPEN  = 2'b11;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_DATA, S_READ, S_BUSY, S_READY, S_DONE
    } eep_state_e;
endpackage

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              sck,
    input  logic              rst_n,
    input  logic              we_one,
    input  logic              we_all,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        always_ff @(posedge sck or negedge rst_n) begin
            if (!rst_n)
                mem_q[i] <= '1;
            else if (we_all || (we_one && waddr == ADDR_W'(i)))
                mem_q[i] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

    // R5: a single-word store lands at the addressed word
    a_r5_store_lands: assert property (@(posedge sck) disable iff (!rst_n)
        we_one |=> mem_q[$past(waddr)] == $past(wdata));

    // R7: an all-word store reaches both ends of the array
    a_r7_fill_ends: assert property (@(posedge sck) disable iff (!rst_n)
        we_all |=> (mem_q[0] == $past(wdata) && mem_q[WORDS-1] == $past(wdata)));
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import serial_eeprom_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 16,
    parameter int BUSY_CYC = 8
) (
    input  logic              sck,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              si,
    output logic              so,
    output logic [ADDR_W-1:0] raddr,
    input  logic [DATA_W-1:0] rdata,
    output logic              we_one,
    output logic              we_all,
    output logic [ADDR_W-1:0] waddr,
    output logic [DATA_W-1:0] wdata
);
    localparam int CNT_W = $clog2(DATA_W + BUSY_CYC + CMD_W) + 1;

    typedef struct packed {
        eep_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] dat;
        logic [DATA_W-1:0] sh;
        logic [ADDR_W-1:0] addr;
        logic              wen;
        logic              dout;
    } ctrl_t;

    ctrl_t r_q, r_d;
    logic [CMD_W-1:0]  cmd_nx;
    logic [DATA_W-1:0] dat_nx;

    always_comb begin
        r_d    = r_q;
        we_one = 1'b0;
        we_all = 1'b0;
        waddr  = r_q.addr;
        wdata  = '1;
        cmd_nx = {r_q.cmd[CMD_W-2:0], si};
        dat_nx = {r_q.dat[DATA_W-2:0], si};
        raddr  = (r_q.st == S_READ) ? r_q.addr + 1'b1 : cmd_nx[ADDR_W-1:0];
        if (!cs) begin
            r_d.st   = S_IDLE;
            r_d.cnt  = '0;
            r_d.dout = 1'b0;
        end else begin
            unique case (r_q.st)
                S_IDLE: if (si) begin
                    r_d.st  = S_CMD;
                    r_d.cnt = '0;
                end
                S_CMD: begin
                    r_d.cmd = cmd_nx;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(CMD_W - 1)) begin
                        r_d.cnt  = '0;
                        r_d.addr = cmd_nx[ADDR_W-1:0];
                        r_d.st   = S_DONE;
                        unique case (cmd_nx[CMD_W-1 -: 2])
                            OP_READ: begin
                                r_d.st   = S_READ;
                                r_d.dout = 1'b0;
                                r_d.sh   = rdata;
                            end
                            OP_WRITE: r_d.st = S_DATA;
                            OP_ERASE: if (r_q.wen) begin
                                we_one = 1'b1;
                                waddr  = cmd_nx[ADDR_W-1:0];
                                r_d.st = S_BUSY;
                            end
                            default: begin
                                unique case (cmd_nx[AFIELD_W-1 -: 2])
                                    EXT_OPEN:  r_d.wen = 1'b1;
                                    EXT_LOCK:  r_d.wen = 1'b0;
                                    EXT_FILL:  r_d.st  = S_DATA;
                                    default: if (r_q.wen) begin
                                        we_all = 1'b1;
                                        r_d.st = S_BUSY;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                S_DATA: begin
                    r_d.dat = dat_nx;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(DATA_W - 1)) begin
                        r_d.cnt = '0;
                        r_d.st  = S_DONE;
                        if (r_q.wen) begin
                            wdata  = dat_nx;
                            r_d.st = S_BUSY;
                            if (r_q.cmd[CMD_W-1 -: 2] == OP_WRITE) we_one = 1'b1;
                            else                                   we_all = 1'b1;
                        end
                    end
                end
                S_READ: begin
                    r_d.dout = r_q.sh[DATA_W-1];
                    r_d.sh   = r_q.sh << 1;
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(DATA_W - 1)) begin
                        r_d.cnt  = '0;
                        r_d.sh   = rdata;
                        r_d.addr = r_q.addr + 1'b1;
                    end
                end
                S_BUSY: begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == CNT_W'(BUSY_CYC - 1)) begin
                        r_d.dout = 1'b1;
                        r_d.st   = S_READY;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign so = r_q.dout;

    // R8: no array change unless programming was enabled
    a_r8_enable_gate: assert property (@(posedge sck) disable iff (!rst_n)
        (we_one || we_all) |-> r_q.wen);

    // R6: one kind of store per edge
    a_r6_one_kind: assert property (@(posedge sck) disable iff (!rst_n)
        $onehot0({we_one, we_all}));

    // R9: output is busy right after a commit
    a_r9_busy_low: assert property (@(posedge sck) disable iff (!rst_n)
        (we_one || we_all) |=> !so);

    // R10: deselect returns to the start-bit hunt with output low
    a_r10_abort: assert property (@(posedge sck) disable iff (!rst_n)
        !cs |=> (r_q.st == S_IDLE && !so));

    // R4: a read keeps streaming while selected
    a_r4_stream: assert property (@(posedge sck) disable iff (!rst_n)
        (r_q.st == S_READ && cs) |=> r_q.st == S_READ);
endmodule

// File: rtl/serial_eeprom.sv
module serial_eeprom #(
    parameter int ADDR_W   = 7,
    parameter int DATA_W   = 16,
    parameter int BUSY_CYC = 8
) (
    input  logic sck,
    input  logic rst_n,
    input  logic cs,
    input  logic si,
    output logic so
);
    logic [ADDR_W-1:0] raddr, waddr;
    logic [DATA_W-1:0] rdata, wdata;
    logic              we_one, we_all;

    eep_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BUSY_CYC)) u_ctrl (
        .sck(sck), .rst_n(rst_n), .cs(cs), .si(si), .so(so),
        .raddr(raddr), .rdata(rdata), .we_one(we_one), .we_all(we_all),
        .waddr(waddr), .wdata(wdata)
    );

    eep_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .sck(sck), .rst_n(rst_n), .we_one(we_one), .we_all(we_all),
        .waddr(waddr), .wdata(wdata), .raddr(raddr), .rdata(rdata)
    );
endmodule

// File: tb/sim_serial_eeprom.sv
module sim_serial_eeprom;
    localparam int AW = 4;
    localparam int NW = 1 << AW;
    localparam int BUSY = 3;

    logic sck = 1'b0, sck_run = 1'b1;
    logic rst_n = 1'b0, cs = 1'b0, si = 1'b0;
    logic so;
    int checks = 0, errors = 0;
    logic [15:0] exp_mem [NW];

    serial_eeprom #(.ADDR_W(AW), .DATA_W(16), .BUSY_CYC(BUSY)) u0 (
        .sck(sck), .rst_n(rst_n), .cs(cs), .si(si), .so(so));

    always begin
        #5;
        if (sck_run) sck = ~sck;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input logic b);
        si = b;
        @(negedge sck);
    endtask

    task automatic deselect();
        cs = 1'b0;
        tick(1'b0);
    endtask

    function automatic logic [7:0] afield(input int a);
        return 8'hB0 | 8'(a % NW);
    endfunction

    function automatic logic [15:0] pattern(input int a);
        return (16'h1357 * 16'(a + 1)) ^ 16'hA0A0;
    endfunction

    task automatic send_cmd(input logic [1:0] op, input logic [7:0] af);
        cs = 1'b1;
        tick(1'b1);
        for (int i = 1; i >= 0; i--) tick(op[i]);
        for (int i = 7; i >= 0; i--) tick(af[i]);
    endtask

    task automatic prog_tail(input logic en, input string req);
        check(req, 16'(so), 16'h0);
        repeat (BUSY - 1) tick(1'b0);
        check(req, 16'(so), 16'h0);
        tick(1'b0);
        check(req, 16'(so), 16'(en));
    endtask

    task automatic send_data(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) tick(d[i]);
    endtask

    task automatic do_write(input int a, input logic [15:0] d, input logic en);
        send_cmd(2'b01, afield(a));
        send_data(d);
        prog_tail(en, en ? "R5/R9 write busy-ready" : "R8 disabled write");
        deselect();
        if (en) exp_mem[a % NW] = d;
    endtask

    task automatic shift_word(output logic [15:0] w);
        for (int i = 15; i >= 0; i--) begin
            tick(1'b0);
            w[i] = so;
        end
    endtask

    task automatic read_run(input int start, input int n, input string req);
        logic [15:0] w;
        send_cmd(2'b10, afield(start));
        check("R3 leading zero", 16'(so), 16'h0);
        for (int k = 0; k < n; k++) begin
            shift_word(w);
            check(req, w, exp_mem[(start + k) % NW]);
        end
        deselect();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] w, hold;
        for (int a = 0; a < NW; a++) exp_mem[a] = 16'hFFFF;
        repeat (3) @(negedge sck);
        check("R1 so low in reset", 16'(so), 16'h0);
        rst_n = 1'b1;
        @(negedge sck);
        check("R1 so low after reset", 16'(so), 16'h0);
        read_run(0, NW + 1, "R1/R4 erased array with wrap");

        // R8: write while disabled changes nothing
        do_write(3, 16'h1234, 1'b0);
        read_run(3, 1, "R8 disabled write ignored");

        // R8: enable, then every word gets a distinct value (R2 junk high address bits)
        send_cmd(2'b00, 8'hC0); deselect();
        for (int a = 0; a < NW; a++) do_write(a, pattern(a), 1'b1);
        read_run(0, NW, "R5/R2 write sweep");
        read_run(NW - 3, 6, "R4 wrap from top");

        // R2: leading zeros before the start bit are ignored
        cs = 1'b1;
        repeat (4) tick(1'b0);
        read_run(9, 2, "R2 leading zeros");

        // R6: single erase, then erase-all
        send_cmd(2'b11, afield(7));
        prog_tail(1'b1, "R6/R9 erase busy-ready");
        deselect();
        exp_mem[7] = 16'hFFFF;
        read_run(6, 3, "R6 erase one word");
        send_cmd(2'b00, 8'h80);
        prog_tail(1'b1, "R6/R9 erase-all busy-ready");
        deselect();
        for (int a = 0; a < NW; a++) exp_mem[a] = 16'hFFFF;
        read_run(0, NW, "R6 erase all");

        // R7: write-all
        send_cmd(2'b00, 8'h40);
        send_data(16'h3C5A);
        prog_tail(1'b1, "R7/R9 write-all busy-ready");
        deselect();
        for (int a = 0; a < NW; a++) exp_mem[a] = 16'h3C5A;
        read_run(0, NW, "R7 write all");

        // R10: partial write aborted by deselect
        send_cmd(2'b01, afield(5));
        for (int i = 0; i < 8; i++) tick(1'b0);
        deselect();
        read_run(5, 1, "R10 aborted write");

        // R8: disable, then every programming instruction is ignored
        send_cmd(2'b00, 8'h00); deselect();
        do_write(2, 16'h0F0F, 1'b0);
        send_cmd(2'b11, afield(4));
        prog_tail(1'b0, "R8 disabled erase");
        deselect();
        send_cmd(2'b00, 8'h80);
        prog_tail(1'b0, "R8 disabled erase-all");
        deselect();
        send_cmd(2'b00, 8'h40);
        send_data(16'h0000);
        prog_tail(1'b0, "R8 disabled write-all");
        deselect();
        read_run(0, NW, "R8 array unchanged");

        // R11: clock halted mid-read
        send_cmd(2'b00, 8'hC0); deselect();
        do_write(2, 16'hC3A5, 1'b1);
        send_cmd(2'b10, afield(2));
        for (int i = 15; i >= 10; i--) begin tick(1'b0); w[i] = so; end
        hold = 16'(so);
        sck_run = 1'b0;
        si = 1'b1;
        #80;
        check("R11 output held while clock stopped", 16'(so), hold);
        sck_run = 1'b1;
        for (int i = 9; i >= 0; i--) begin tick(1'b0); w[i] = so; end
        check("R11 read resumes after halt", w, 16'hC3A5);
        shift_word(w);
        check("R11/R4 next word after halt", w, exp_mem[3]);
        deselect();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule